// File: doc/BRIEF.md
# PHY Power Mode Controller

This block turns three power-saving configuration bits, held in the management register file of a 10/100 Ethernet transceiver, into the enable and tri-state controls that the transceiver's circuits need. It selects between normal operation, whole-chip power-down, line-activity-driven receive power management, and a transmit high-impedance mode. All of its outputs are registered, so the analog and clock controls it drives change only on clock edges and never glitch.

The register bits come in as plain levels: power-down is bit 11 of control register 0, receive power management is bit 0 of register 16, and transmit high impedance is bit 12 of register 16. The register file keeps these bits, and they are cleared only by software or by reset. Nothing in this block gates the management clock or the register access path, so register access keeps working in every mode, including power-down. The line signal-detect input is asynchronous. It passes through a synchronizer of `SYNC_STAGES` flops (default 2) before it can change the receive power enable.

There is no data stream through this block. Every pin is a plain control or status level, and there is no handshake.

Top module: `phy_pwr_mode_ctl`

## Requirements
- R1: One clock edge after `cfg_pwrdn` (register 0, bit 11) is sampled high, `pd_en` is 1 and `rx_pwr_en`, `rxclk_en`, `tx_drv_oe`, `txclk_oe` and `txclk_pu` are all 0.
- R2: One clock edge after `cfg_pwrdn` is sampled low again, the outputs follow the receive and transmit modes as though power-down had never been set. No other action is needed to leave power-down.
- R3: When `cfg_rx_autopm` (register 16, bit 0) is 1, `link_100m` is 1 and power-down is off, `rx_pwr_en` is 0 whenever the synchronized signal detect is 0.
- R4: In the mode of R3, a rise of `sig_det` that is sampled at edge k shows up as `rx_pwr_en`=1 after edge k+2. A fall of `sig_det` shows up with the same latency.
- R5: In the mode of R3, `rxclk_en` is 0 one edge after `rx_active` is sampled low, and 1 one edge after it is sampled high.
- R6: When `link_100m` is 0, `cfg_rx_autopm` has no effect: `rx_pwr_en` and `rxclk_en` stay 1 (power-down off) whatever `sig_det` and `rx_active` do.
- R7: One edge after `cfg_tx_hiz` (register 16, bit 12) is sampled 1 with power-down off, `tx_drv_oe`=0, `txclk_oe`=0 and `txclk_pu`=1. The receive outputs are unaffected.
- R8: Clearing `cfg_tx_hiz`, or applying reset, restores `tx_drv_oe`=1, `txclk_oe`=1 and `txclk_pu`=0.
- R9: While `rst_n` is low, and right after it goes low (asynchronously), the outputs are `pd_en`=0, `rx_pwr_en`=1, `rxclk_en`=1, `tx_drv_oe`=1, `txclk_oe`=1 and `txclk_pu`=0. The synchronizer restarts from "no signal".
- R10: Power-down overrides both receive power management and transmit high impedance. During power-down the TX_CLK pull-up is also off (`txclk_pu`=0), even when `cfg_tx_hiz` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwrdn | input | 1 | Chip power-down bit (reg 0 bit 11) |
| cfg_rx_autopm | input | 1 | Receive power management bit (reg 16 bit 0) |
| cfg_tx_hiz | input | 1 | Transmit high-impedance bit (reg 16 bit 12) |
| link_100m | input | 1 | 1 when the link runs at 100 Mb/s |
| sig_det | input | 1 | Asynchronous valid-line-signal detect |
| rx_active | input | 1 | Receive data currently present |
| pd_en | output | 1 | Global power-down enable |
| rx_pwr_en | output | 1 | Receive-domain power enable |
| rxclk_en | output | 1 | Receive clock gate (1 = clock runs) |
| tx_drv_oe | output | 1 | Transmit line driver output enable |
| txclk_oe | output | 1 | TX_CLK output enable |
| txclk_pu | output | 1 | TX_CLK weak pull-up enable |

## Verification
The synchronized wake from `sig_det` can land in the same cycle that `cfg_pwrdn` changes. The bench provokes this by raising `sig_det` and then setting power-down exactly two edges later, so both arrive at the decision register at one edge. It also releases power-down on the edge where a synchronized fall lands. A cycle-by-cycle reference model that keeps a history of `sig_det` judges every such cycle, and power-down must win whenever it is set. A change of `rx_active` together with a change of `link_100m` is judged by the same model.

// File: rtl/pwrmode_pkg.sv
`timescale 1ns/1ps
package pwrmode_pkg;

  // Transmit-side pad controls, kept together so they change on one edge
  typedef struct packed {
    logic drv_oe;
    logic clk_oe;
    logic clk_pu;
  } tx_pad_t;

  localparam tx_pad_t TX_PAD_ACTIVE = '{drv_oe: 1'b1, clk_oe: 1'b1, clk_pu: 1'b0};
  localparam tx_pad_t TX_PAD_HIZ    = '{drv_oe: 1'b0, clk_oe: 1'b0, clk_pu: 1'b1};
  localparam tx_pad_t TX_PAD_OFF    = '{drv_oe: 1'b0, clk_oe: 1'b0, clk_pu: 1'b0};

endpackage

// File: rtl/pwrmode_sync.sv
`timescale 1ns/1ps
module pwrmode_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_sync = chain[LAST];
endmodule

// File: rtl/pwrmode_rx.sv
`timescale 1ns/1ps
module pwrmode_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic autopm_req,
  input  logic link_100m,
  input  logic sig_ok_sync,
  input  logic rx_active,
  output logic rx_pwr_en,
  output logic rxclk_en
);
  // Auto power management only applies at 100 Mb/s
  logic pm_live;
  logic pwr_next;
  logic clk_next;

  always_comb begin
    pm_live  = autopm_req && link_100m;
    pwr_next = 1'b1;
    clk_next = 1'b1;
    if (pd_req) begin
      pwr_next = 1'b0;
      clk_next = 1'b0;
    end else if (pm_live) begin
      pwr_next = sig_ok_sync;
      clk_next = rx_active;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pwr_en <= 1'b1;
      rxclk_en  <= 1'b1;
    end else begin
      rx_pwr_en <= pwr_next;
      rxclk_en  <= clk_next;
    end
  end

  assert_rx_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req && autopm_req && link_100m && !sig_ok_sync) |=> !rx_pwr_en);

  assert_rx_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req && autopm_req && link_100m && sig_ok_sync) |=> rx_pwr_en);

  assert_rxclk_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req && autopm_req && link_100m) |=> (rxclk_en == $past(rx_active)));

  assert_slow_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req && !link_100m) |=> (rx_pwr_en && rxclk_en));
endmodule

// File: rtl/pwrmode_tx.sv
`timescale 1ns/1ps
module pwrmode_tx
  import pwrmode_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pd_req,
  input  logic    hiz_req,
  output tx_pad_t pad
);
  tx_pad_t pad_next;

  always_comb begin
    if (pd_req)       pad_next = TX_PAD_OFF;
    else if (hiz_req) pad_next = TX_PAD_HIZ;
    else              pad_next = TX_PAD_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad <= TX_PAD_ACTIVE;
    else        pad <= pad_next;
  end

  assert_tx_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_req && !pd_req) |=> (!pad.drv_oe && !pad.clk_oe && pad.clk_pu));

  assert_tx_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiz_req && !pd_req) |=> (pad.drv_oe && pad.clk_oe && !pad.clk_pu));

  assert_pd_no_pullup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> !pad.clk_pu);

  // A pulled-up clock pin must never be driven at the same time
  assert_pu_vs_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pad.clk_pu |-> !pad.clk_oe);
endmodule

// File: rtl/phy_pwr_mode_ctl.sv
`timescale 1ns/1ps
module phy_pwr_mode_ctl
  import pwrmode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pwrdn,
  input  logic cfg_rx_autopm,
  input  logic cfg_tx_hiz,
  input  logic link_100m,
  input  logic sig_det,
  input  logic rx_active,
  output logic pd_en,
  output logic rx_pwr_en,
  output logic rxclk_en,
  output logic tx_drv_oe,
  output logic txclk_oe,
  output logic txclk_pu
);
  logic    sig_ok_sync;
  tx_pad_t tx_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_en <= 1'b0;
    else        pd_en <= cfg_pwrdn;
  end

  pwrmode_sync #(.STAGES(SYNC_STAGES)) u_sigdet_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sig_det),
    .q_sync  (sig_ok_sync)
  );

  pwrmode_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (cfg_pwrdn),
    .autopm_req  (cfg_rx_autopm),
    .link_100m   (link_100m),
    .sig_ok_sync (sig_ok_sync),
    .rx_active   (rx_active),
    .rx_pwr_en   (rx_pwr_en),
    .rxclk_en    (rxclk_en)
  );

  pwrmode_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_req  (cfg_pwrdn),
    .hiz_req (cfg_tx_hiz),
    .pad     (tx_pad)
  );

  assign tx_drv_oe = tx_pad.drv_oe;
  assign txclk_oe  = tx_pad.clk_oe;
  assign txclk_pu  = tx_pad.clk_pu;

  assert_pd_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pwrdn |=> (pd_en && !rx_pwr_en && !rxclk_en && !tx_drv_oe && !txclk_oe && !txclk_pu));

  assert_pd_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pwrdn && !cfg_rx_autopm && !cfg_tx_hiz) |=> (!pd_en && rx_pwr_en && rxclk_en && tx_drv_oe));

  assert_hiz_keeps_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx_hiz && !cfg_pwrdn && !cfg_rx_autopm) |=> (rx_pwr_en && rxclk_en));
endmodule

// File: tb/tb_phy_pwr_mode_ctl.sv
`timescale 1ns/1ps
module tb_phy_pwr_mode_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pwrdn = 0, cfg_rx_autopm = 0, cfg_tx_hiz = 0;
  logic link_100m = 1, sig_det = 0, rx_active = 0;
  logic pd_en, rx_pwr_en, rxclk_en, tx_drv_oe, txclk_oe, txclk_pu;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  string req = "R9";

  // Expected outputs
  logic e_pd, e_rxp, e_rxc, e_oe, e_pu;
  logic sd_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_pwr_mode_ctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_pwrdn(cfg_pwrdn), .cfg_rx_autopm(cfg_rx_autopm),
    .cfg_tx_hiz(cfg_tx_hiz), .link_100m(link_100m), .sig_det(sig_det),
    .rx_active(rx_active), .pd_en(pd_en), .rx_pwr_en(rx_pwr_en), .rxclk_en(rxclk_en),
    .tx_drv_oe(tx_drv_oe), .txclk_oe(txclk_oe), .txclk_pu(txclk_pu)
  );

  // Reference model: behaviour taken from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_hist.delete();
      e_pd = 0; e_rxp = 1; e_rxc = 1; e_oe = 1; e_pu = 0;          // R9
    end else begin
      logic seen;
      sd_hist.push_front(sig_det);
      if (sd_hist.size() > 3) void'(sd_hist.pop_back());
      seen = (sd_hist.size() >= 3) ? sd_hist[2] : 1'b0;            // R4: two edges of delay
      e_pd = cfg_pwrdn;
      if (cfg_pwrdn) begin                                         // R1, R10
        e_rxp = 0; e_rxc = 0; e_oe = 0; e_pu = 0;
      end else begin
        e_rxp = (cfg_rx_autopm && link_100m) ? seen : 1'b1;        // R3, R6
        e_rxc = (cfg_rx_autopm && link_100m) ? rx_active : 1'b1;   // R5
        e_oe  = !cfg_tx_hiz;                                       // R7, R8
        e_pu  = cfg_tx_hiz;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [5:0] got, exp;
      got = {pd_en, rx_pwr_en, rxclk_en, tx_drv_oe, txclk_oe, txclk_pu};
      exp = {e_pd, e_rxp, e_rxc, e_oe, e_oe, e_pu};
      n_cmp++;
      if (got !== exp) begin
        n_bad++;
        $display("FAIL %s t=%0t got=%b expected=%b (pd,rxp,rxc,txoe,clkoe,pu)", req, $time, got, exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog got=%0d cycles expected<=%0d", cycles, WATCHDOG);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    step(3);                                   // R9: reset values held
    rst_n = 1;
    step(2);

    req = "R6"; cfg_rx_autopm = 1; link_100m = 0; sig_det = 0; rx_active = 0;
    step(6);
    req = "R3"; link_100m = 1;
    step(5);
    req = "R4"; sig_det = 1;
    step(4);
    req = "R5"; rx_active = 1; step(3); rx_active = 0; step(3);
    rx_active = 1; step(1); rx_active = 0; step(2);
    req = "R4"; sig_det = 0; step(4);

    req = "R7"; cfg_rx_autopm = 0; cfg_tx_hiz = 1; step(4);
    req = "R8"; cfg_tx_hiz = 0; step(3);
    cfg_tx_hiz = 1; step(3);
    rst_n = 0; step(2);                        // R8: reset restores transmit
    cfg_tx_hiz = 0; rst_n = 1; step(3);

    req = "R1"; cfg_pwrdn = 1; step(4);
    req = "R10"; cfg_rx_autopm = 1; cfg_tx_hiz = 1; sig_det = 1; rx_active = 1; step(5);
    req = "R2"; cfg_pwrdn = 0; step(4);
    cfg_tx_hiz = 0; step(3);

    // Collision: synchronized wake lands on the edge where power-down is set
    req = "R10"; sig_det = 0; step(4);
    sig_det = 1; step(2); cfg_pwrdn = 1; step(3);
    // Release power-down on the edge where a synchronized fall lands
    req = "R2"; sig_det = 0; step(2); cfg_pwrdn = 0; step(4);

    // Pseudo-random mix of every input
    req = "R4";
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sig_det       = lfsr[0];
      rx_active     = lfsr[3];
      link_100m     = lfsr[5] | lfsr[6];
      cfg_rx_autopm = lfsr[7] | lfsr[8];
      cfg_tx_hiz    = lfsr[9] & lfsr[10];
      cfg_pwrdn     = lfsr[11] & lfsr[12] & lfsr[13];
      step(1);
    end
    step(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule